// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block provides eight independent down-counters, each 32 bits wide by default, behind a single 32-bit register bus. Every channel has a live count, a reload value and two match values. One shared control word carries a four-bit configuration field for each channel: run enable, tick-source select, overflow-interrupt enable and pulse-mode enable. A second control word is held for software and is read back unchanged.

A running channel steps down by one on each strobe of its chosen tick source. That source is either the slow external tick or the fast bus-rate tick. When a tick finds the count already at zero, the channel expires. It then restarts from its reload value and keeps running, and it can raise a single-cycle pulse on its own interrupt line. Stopping a channel reloads its count.

A write to the control word takes effect from the cycle after the write. As a result, a channel that is being switched off is stopped before any of its other settings apply. A channel that is being switched on starts only once its new settings are in place.

Top module: `timer_bank`

## Requirements
- R1: After reset every control field and the second control word are zero, every count, reload and match register reads zero, all interrupt lines are low and the configuration-error output is low.
- R2: Channels 0 to 2 decode at offsets 0x00 to 0x2C with channel number offset[7:4]. Channels 3 to 7 decode at 0x40 to 0x8C with channel number offset[7:4] minus one. Within a channel, offset[3:2] selects 0 = count, 1 = reload, 2 = match A, 3 = match B. The first control word is at 0x30 and the second at 0x34. Read data appears on bus_rdata in the cycle after the read request.
- R3: An access is unmapped if its offset lies outside those ranges (0x38, 0x3C, 0x90 and above), if bits [1:0] are non-zero, or if any address bit above bit 7 is set. Unmapped reads return zero and unmapped writes change nothing.
- R4: The first control word holds channel n's field in bits [4n+3:4n]. Bit 0 is enable, bit 1 selects the slow tick (set) or the fast tick (clear), bit 2 is overflow-interrupt enable and bit 3 is pulse-mode enable. The word reads back as written.
- R5: An enabled channel decrements by exactly one on each cycle in which its selected tick strobe is high. Strobes on the unselected source have no effect.
- R6: A selected tick that arrives while the count is zero is an expiry. The count is loaded from the reload register and the channel keeps running.
- R7: An expiry drives the channel's irq bit high for exactly one cycle, in the cycle after the expiry tick. This happens only if its overflow-interrupt bit is set or at least one of its match registers is zero; otherwise the line stays low.
- R8: A control write that clears a channel's enable bit loads its count from its reload register, even when a tick arrives in the same cycle.
- R9: A write to the count register loads the count only while the channel is enabled. While the channel is disabled such a write is ignored.
- R10: A reload write while the channel is disabled also loads the count. While the channel is enabled the count is left alone and the new value is used at the next expiry.
- R11: A control write that sets the enable bit does not count a tick that arrives in the same cycle. The tick source chosen by the same write governs the first counted tick.
- R12: A first-control-word write that sets the pulse bit of any channel below 4 raises cfg_err for one cycle, starting the cycle after the write. Pulse bits of channels 4 to 7 raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| slow_tick | input | 1 | Slow external tick strobe |
| fast_tick | input | 1 | Bus-rate tick strobe |
| irq | output | 8 | Per-channel expiry pulse |
| cfg_err | output | 1 | Pulse bit set on a channel without pulse support |

## Verification
The bench targets the address gap and aliasing. If a decoder ignored the low address bits or the high address bits, a stray write would land in channel 0's reload register. If it mishandled the minus-one mapping, writes would land one channel off or lose channel 7. It also times a tick against the very cycle of an enabling or disabling control write: a design that applied enable at once would lose one count, and one that counted before disabling would reload too late. Finally it checks that interrupts are suppressed when both match values are non-zero and the overflow bit is clear, that count writes to a stopped channel are dropped, and that a reload written while a channel runs is held until the next expiry. A design that got any of these wrong would show a wrong count or a missing or extra irq pulse.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
   localparam int NUM_TMR = 8;
   localparam int FLD_W   = 4;
   localparam int CTL_W   = NUM_TMR * FLD_W;
   localparam int IDX_W   = $clog2(NUM_TMR);

   typedef enum logic [1:0] {
      W_COUNT   = 2'd0,
      W_RELOAD  = 2'd1,
      W_MATCH_A = 2'd2,
      W_MATCH_B = 2'd3
   } word_e;

   typedef struct packed {
      logic             hit_tmr;
      logic             hit_ctl1;
      logic             hit_ctl2;
      logic [IDX_W-1:0] idx;
      word_e            word;
   } dec_t;
endpackage

// File: rtl/timer_bank_dec.sv
module timer_bank_dec
   import timer_bank_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   localparam logic [7:0] CTL1_OFF = 8'h30;
   localparam logic [7:0] CTL2_OFF = 8'h34;
   localparam logic [7:0] LOW_END  = 8'h30;
   localparam logic [7:0] HIGH_BEG = 8'h40;
   localparam logic [7:0] HIGH_END = 8'h8C;

   if (ADDR_W < 9) begin : g_bad_addr
      $error("timer_bank_dec: ADDR_W must be at least 9");
   end

   logic [7:0] off;
   logic       upper_set;
   logic       aligned;

   assign off       = addr[7:0];
   assign upper_set = |addr[ADDR_W-1:8];
   assign aligned   = (addr[1:0] == 2'b00);

   always_comb begin
      dec = '0;
      if (!upper_set && aligned) begin
         if (off < LOW_END) begin
            dec.hit_tmr = 1'b1;
            dec.idx     = IDX_W'(off[7:4]);
            dec.word    = word_e'(off[3:2]);
         end else if (off == CTL1_OFF) begin
            dec.hit_ctl1 = 1'b1;
         end else if (off == CTL2_OFF) begin
            dec.hit_ctl2 = 1'b1;
         end else if (off >= HIGH_BEG && off <= HIGH_END) begin
            dec.hit_tmr = 1'b1;
            dec.idx     = IDX_W'(off[7:4] - 4'd1);
            dec.word    = word_e'(off[3:2]);
         end
      end
   end
endmodule

// File: rtl/timer_bank_ctrl.sv
module timer_bank_ctrl
   import timer_bank_pkg::*;
#(
   parameter int FIRST_PULSE = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_ctl1,
   input  logic               wr_ctl2,
   input  logic [31:0]        wdata,
   output logic [CTL_W-1:0]   ctl1,
   output logic [31:0]        ctl2,
   output logic [NUM_TMR-1:0] en_fall,
   output logic               cfg_err
);
   if (FIRST_PULSE < 0 || FIRST_PULSE > NUM_TMR) begin : g_bad_fp
      $error("timer_bank_ctrl: FIRST_PULSE out of range");
   end

   logic [NUM_TMR-1:0] bad_pulse;

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_fld
      assign en_fall[i] = wr_ctl1 & ctl1[FLD_W*i] & ~wdata[FLD_W*i];
      if (i < FIRST_PULSE) begin : g_nopulse
         assign bad_pulse[i] = wdata[FLD_W*i + 3];
      end else begin : g_pulse_ok
         assign bad_pulse[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl1    <= '0;
         ctl2    <= '0;
         cfg_err <= 1'b0;
      end else begin
         if (wr_ctl1) ctl1 <= wdata[CTL_W-1:0];
         if (wr_ctl2) ctl2 <= wdata;
         cfg_err <= wr_ctl1 & (|bad_pulse);
      end
   end

   assert_err_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(wr_ctl1))
      else $error("cfg_err without a control write");

   assert_ctl_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl1 |=> ctl1 == $past(wdata[CTL_W-1:0]))
      else $error("control word not captured");
endmodule

// File: rtl/timer_bank_chan.sv
module timer_bank_chan #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             slow_sel,
   input  logic             ovf_ie,
   input  logic             en_fall,
   input  logic             cnt_we,
   input  logic             rld_we,
   input  logic             ma_we,
   input  logic             mb_we,
   input  logic [CNT_W-1:0] wd,
   input  logic             slow_tick,
   input  logic             fast_tick,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] rld,
   output logic [CNT_W-1:0] mat_a,
   output logic [CNT_W-1:0] mat_b,
   output logic             irq
);
   logic tick;
   logic at_zero;
   logic expire;
   logic irq_ok;

   assign tick    = slow_sel ? slow_tick : fast_tick;
   assign at_zero = (cnt == '0);
   assign expire  = en & ~en_fall & ~cnt_we & tick & at_zero;
   assign irq_ok  = ovf_ie | (mat_a == '0) | (mat_b == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         rld   <= '0;
         mat_a <= '0;
         mat_b <= '0;
         irq   <= 1'b0;
      end else begin
         if (rld_we) rld   <= wd;
         if (ma_we)  mat_a <= wd;
         if (mb_we)  mat_b <= wd;
         irq <= expire & irq_ok;
         if (en_fall) begin
            cnt <= rld;
         end else if (en) begin
            if (cnt_we)      cnt <= wd;
            else if (tick)   cnt <= at_zero ? rld : cnt - 1'b1;
         end else if (rld_we) begin
            cnt <= wd;
         end
      end
   end

   assert_disable_reloads_R8: assert property (@(posedge clk) disable iff (!rst_n)
      en_fall |=> cnt == $past(rld))
      else $error("disable did not reload count");

   assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !rld_we) |=> $stable(cnt))
      else $error("stopped channel changed count");

   assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !en_fall && !cnt_we && tick && cnt != '0) |=> cnt == $past(cnt) - 1'b1)
      else $error("count did not step by one");

   assert_irq_with_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cnt == $past(rld))
      else $error("interrupt without reload");
endmodule

// File: rtl/timer_bank.sv
module timer_bank
   import timer_bank_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int CNT_W       = 32,
   parameter int FIRST_PULSE = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic               slow_tick,
   input  logic               fast_tick,
   output logic [NUM_TMR-1:0] irq,
   output logic               cfg_err
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("timer_bank: CNT_W must be 1..32");
   end

   dec_t               dec;
   logic               wr_any;
   logic               rd_any;
   logic [CTL_W-1:0]   ctl1;
   logic [31:0]        ctl2;
   logic [NUM_TMR-1:0] en_fall;
   logic [31:0]        rd_val;
   logic [CNT_W-1:0]   cnt_a [NUM_TMR];
   logic [CNT_W-1:0]   rld_a [NUM_TMR];
   logic [CNT_W-1:0]   ma_a  [NUM_TMR];
   logic [CNT_W-1:0]   mb_a  [NUM_TMR];

   assign wr_any = bus_sel &  bus_wr;
   assign rd_any = bus_sel & ~bus_wr;

   timer_bank_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   timer_bank_ctrl #(.FIRST_PULSE(FIRST_PULSE)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctl1 (wr_any & dec.hit_ctl1),
      .wr_ctl2 (wr_any & dec.hit_ctl2),
      .wdata   (bus_wdata),
      .ctl1    (ctl1),
      .ctl2    (ctl2),
      .en_fall (en_fall),
      .cfg_err (cfg_err)
   );

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
      logic sel_me;
      assign sel_me = wr_any & dec.hit_tmr & (dec.idx == IDX_W'(i));

      timer_bank_chan #(.CNT_W(CNT_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (ctl1[FLD_W*i]),
         .slow_sel  (ctl1[FLD_W*i + 1]),
         .ovf_ie    (ctl1[FLD_W*i + 2]),
         .en_fall   (en_fall[i]),
         .cnt_we    (sel_me & (dec.word == W_COUNT)),
         .rld_we    (sel_me & (dec.word == W_RELOAD)),
         .ma_we     (sel_me & (dec.word == W_MATCH_A)),
         .mb_we     (sel_me & (dec.word == W_MATCH_B)),
         .wd        (bus_wdata[CNT_W-1:0]),
         .slow_tick (slow_tick),
         .fast_tick (fast_tick),
         .cnt       (cnt_a[i]),
         .rld       (rld_a[i]),
         .mat_a     (ma_a[i]),
         .mat_b     (mb_a[i]),
         .irq       (irq[i])
      );
   end

   always_comb begin
      rd_val = '0;
      if (dec.hit_ctl1) begin
         rd_val = 32'(ctl1);
      end else if (dec.hit_ctl2) begin
         rd_val = ctl2;
      end else if (dec.hit_tmr) begin
         unique case (dec.word)
            W_COUNT:   rd_val = 32'(cnt_a[dec.idx]);
            W_RELOAD:  rd_val = 32'(rld_a[dec.idx]);
            W_MATCH_A: rd_val = 32'(ma_a[dec.idx]);
            W_MATCH_B: rd_val = 32'(mb_a[dec.idx]);
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_any) bus_rdata <= rd_val;
   end

   assert_unmapped_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && !dec.hit_tmr && !dec.hit_ctl1 && !dec.hit_ctl2) |=> bus_rdata == '0)
      else $error("unmapped read returned data");

   assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dec.hit_tmr, dec.hit_ctl1, dec.hit_ctl2}))
      else $error("address decoded to two targets");
endmodule

// File: tb/timer_bank_test.sv
module timer_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        slow_tick = 1'b0;
   logic        fast_tick = 1'b0;
   logic [7:0]  irq;
   logic        cfg_err;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   timer_bank uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .slow_tick (slow_tick),
      .fast_tick (fast_tick),
      .irq       (irq),
      .cfg_err   (cfg_err)
   );

   typedef struct packed {
      logic [11:0] a;
      logic        w;
      logic [31:0] d;
      logic [31:0] e;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{12'h004, 1'b1, 32'h1111_1111, 32'h1111_1111},
      '{12'h014, 1'b1, 32'h2222_2222, 32'h2222_2222},
      '{12'h024, 1'b1, 32'h3333_3333, 32'h3333_3333},
      '{12'h044, 1'b1, 32'h4444_4444, 32'h4444_4444},
      '{12'h054, 1'b1, 32'h5555_5555, 32'h5555_5555},
      '{12'h064, 1'b1, 32'h6666_6666, 32'h6666_6666},
      '{12'h074, 1'b1, 32'h7777_7777, 32'h7777_7777},
      '{12'h084, 1'b1, 32'h8888_8888, 32'h8888_8888},
      '{12'h008, 1'b1, 32'h0000_A5A5, 32'h0000_A5A5},
      '{12'h08C, 1'b1, 32'h0BAD_F00D, 32'h0BAD_F00D},
      '{12'h034, 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
      '{12'h038, 1'b1, 32'h0000_0005, 32'h0000_0000},
      '{12'h03C, 1'b1, 32'h0000_0006, 32'h0000_0000},
      '{12'h090, 1'b1, 32'h0000_0007, 32'h0000_0000},
      '{12'h104, 1'b1, 32'h0000_0099, 32'h0000_0000},
      '{12'h006, 1'b1, 32'h0000_0042, 32'h0000_0000},
      '{12'h004, 1'b0, 32'h0000_0000, 32'h1111_1111},
      '{12'h000, 1'b0, 32'h0000_0000, 32'h1111_1111}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic ft = 1'b0);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; fast_tick = ft;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; fast_tick = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic ticks(input int n, input logic slow);
      if (slow) slow_tick = 1'b1; else fast_tick = 1'b1;
      repeat (n) @(negedge clk);
      slow_tick = 1'b0; fast_tick = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   initial begin
      for (int k = 0; k < 100000; k++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {24'd0, irq}, 32'd0);
      chk("R1 cfg_err", {31'd0, cfg_err}, 32'd0);
      rd_chk("R1 ctl1", 12'h030, 32'd0);
      rd_chk("R1 count ch5", 12'h060, 32'd0);
      rd_chk("R1 matchB ch7", 12'h08C, 32'd0);

      // R2/R3/R10 vector table
      for (int v = 0; v < NV; v++) begin
         if (VECS[v].w) wr(VECS[v].a, VECS[v].d);
         rd_chk($sformatf("R2/R3/R10 vec%0d", v), VECS[v].a, VECS[v].e);
      end

      // R5 R6 R7: channel 1, fast tick, matches zero
      wr(12'h01C, 32'd0);
      wr(12'h014, 32'd3);
      wr(12'h030, 32'h10);
      ticks(3, 1'b0);
      rd_chk("R5 count at zero", 12'h010, 32'd0);
      chk("R7 no irq before expiry", {24'd0, irq}, 32'd0);
      ticks(1, 1'b0);
      chk("R7 irq pulse", {31'd0, irq[1]}, 32'd1);
      @(negedge clk);
      chk("R7 irq one cycle", {31'd0, irq[1]}, 32'd0);
      rd_chk("R6 reloaded", 12'h010, 32'd3);

      // R7 suppression with both matches non-zero
      wr(12'h018, 32'd5);
      wr(12'h01C, 32'd6);
      ticks(3, 1'b0);
      ticks(1, 1'b0);
      chk("R7 suppressed", {31'd0, irq[1]}, 32'd0);
      wr(12'h030, 32'h50);
      ticks(3, 1'b0);
      ticks(1, 1'b0);
      chk("R7 overflow bit", {31'd0, irq[1]}, 32'd1);
      rd_chk("R6 reload after ovf", 12'h010, 32'd3);

      // R9 / R8
      wr(12'h010, 32'd100);
      rd_chk("R9 count write enabled", 12'h010, 32'd100);
      wr(12'h030, 32'h0);
      rd_chk("R8 disable reload", 12'h010, 32'd3);
      wr(12'h010, 32'd77);
      rd_chk("R9 count write ignored", 12'h010, 32'd3);

      // R10 reload while running
      wr(12'h030, 32'h10);
      wr(12'h014, 32'd9);
      rd_chk("R10 count untouched", 12'h010, 32'd3);
      ticks(4, 1'b0);
      rd_chk("R10 new reload used", 12'h010, 32'd9);
      wr(12'h030, 32'h0);

      // R5 slow source on channel 4
      wr(12'h054, 32'd10);
      wr(12'h030, 32'h0003_0000);
      ticks(5, 1'b0);
      rd_chk("R5 fast ignored", 12'h050, 32'd10);
      ticks(2, 1'b1);
      rd_chk("R5 slow counted", 12'h050, 32'd8);
      wr(12'h030, 32'h0);

      // R11 ordering on channel 2
      wr(12'h024, 32'd5);
      wr(12'h030, 32'h100, 1'b1);
      rd_chk("R11 enable last", 12'h020, 32'd5);
      ticks(2, 1'b0);
      rd_chk("R11 counting", 12'h020, 32'd3);
      wr(12'h030, 32'h0, 1'b1);
      rd_chk("R8 disable first", 12'h020, 32'd5);
      wr(12'h030, 32'h300, 1'b1);
      ticks(3, 1'b0);
      rd_chk("R11 new source applies", 12'h020, 32'd5);
      ticks(1, 1'b1);
      rd_chk("R11 slow counted", 12'h020, 32'd4);
      wr(12'h030, 32'h0);

      // R12 pulse error
      wr(12'h030, 32'h8);
      chk("R12 low channel pulse", {31'd0, cfg_err}, 32'd1);
      @(negedge clk);
      chk("R12 err one cycle", {31'd0, cfg_err}, 32'd0);
      wr(12'h030, 32'h8_0000);
      chk("R12 high channel pulse", {31'd0, cfg_err}, 32'd0);
      rd_chk("R4 readback", 12'h030, 32'h8_0000);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule